// File: doc/BRIEF.md
# Eight-button serial pad interface

This block carries the levels of eight buttons across three signals: a mode line, a pad clock and a data line. On the pad side sits an eight-stage register with eight parallel inputs. While the mode line is high, each stage simply follows its own button input. No clock edge is involved, and pad clock pulses have no effect. While the mode line is low, each rising edge of the pad clock moves every stage one place towards the last stage, and the first stage loads the serial input. The pad register has no reset. It is cleared by holding the serial input low while it is pulsed eight times.

On the host side, a poller drives the mode line and the pad clock from a system-clock tick divider and samples the data line. Each poll runs as follows:

1. The mode line is held high for a set number of ticks, and then dropped.
2. After one settle tick, the host takes the first sample. This sample shows button 8 (A), before any pad clock pulse.
3. The host issues eight pad clock pulses and takes one further sample after each of the first seven.
4. It waits for a gap and starts the next poll.

Buttons are active low on the pad. The host inverts the samples, so its output vector has a 1 for each pressed button. A one-cycle strobe marks each new vector.

Top module: `spad_link`

## Requirements
- R1: While the mode line is high, the pad register follows the button inputs one system cycle later, with no pad clock edge. `pad_data` then shows the level of button 8 (`btn_n[7]`).
- R2: While the mode line is low, each rising pad clock edge shifts the register towards stage 8, and stage 1 takes `ser_in`. Successive samples therefore show `btn_n[7]`, `btn_n[6]` and so on, down to `btn_n[0]`.
- R3: Button changes made while the mode line is low do not alter the vector reported by that poll.
- R4: After the eighth pad clock pulse of a poll, and until the next capture, `pad_data` equals the `ser_in` level that was held through that poll. Holding it at 0 clears the register.
- R5: The first sample is taken before the first pad clock pulse. `buttons[7]` reports button 8 (`btn_n[7]`) and `buttons[0]` reports button 1 (`btn_n[0]`). An input level of 0 (pressed) is reported as 1.
- R6: Each poll has exactly eight rising pad clock edges, all while the mode line is low. The pad clock is high whenever the mode line is high.
- R7: `buttons_valid` is high for exactly one cycle per poll, in the cycle in which `buttons` shows the new vector.
- R8: While reset is active, `pad_latch` is 1, `pad_clk` is 1, `buttons` is 0 and `buttons_valid` is 0.
- R9: With divider DIV, the timing is as follows. The mode line stays high for `LATCH_TICKS*DIV` cycles. Each pad clock low phase lasts `DIV` cycles. Successive strobes are `(LATCH_TICKS+GAP_TICKS+17)*DIV` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (host side only) |
| btn_n | input | 8 | Button levels at the pad, 0 = pressed; bit i is button i+1 |
| ser_in | input | 1 | Serial input into stage 1 of the pad register |
| pad_latch | output | 1 | Mode line, 1 = parallel capture, 0 = serial shift |
| pad_clk | output | 1 | Pad clock, idles high |
| pad_data | output | 1 | Data line, driven from stage 8 |
| buttons | output | 8 | Last polled vector, 1 = pressed |
| buttons_valid | output | 1 | One-cycle strobe marking a new vector |

## Verification
Results fall due at fixed points:

- **Capture:** the pad register shows a new capture one cycle after the mode line samples the buttons.
- **Clear:** the value moved in from the serial input appears on the data line after the eighth pulse. The bench checks it at the moment the mode line rises.
- **Vector:** a new vector and its strobe arrive on a fixed period of `(LATCH_TICKS+GAP_TICKS+17)*DIV` cycles.

The bench has a driver and a monitor. The driver sets the buttons while the mode line is high and queues the inverted pattern. It then scrambles the buttons as soon as the mode line drops. The monitor pops one item at each strobe. It measures the strobe spacing, the width of the mode line, the pulse count and the low-phase length. All samples are taken on the falling clock edge.

// File: rtl/spad_pkg.sv
// Package: shared types for the serial pad link.
// Assumes: the host sequencer walks these phases in the listed order.
package spad_pkg;

    // Host poll phases
    typedef enum logic [2:0] {
        PH_LATCH  = 3'd0,
        PH_SETTLE = 3'd1,
        PH_LOW    = 3'd2,
        PH_HIGH   = 3'd3,
        PH_GAP    = 3'd4
    } poll_phase_e;

    // Helper to size counters (at least one bit)
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/spad_tick.sv
// Module: spad_tick
// Issues a one-cycle tick every DIV system cycles. The tick paces
// every phase of the host poll.
// Assumes: DIV >= 2, so that the pad register settles before a sample.
module spad_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = spad_pkg::cnt_width(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Free-running divide counter, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/spad_pad_reg.sv
// Module: spad_pad_reg
// Pad-side parallel-in, serial-out register.
// While the mode line is high, every stage follows its button input.
// While it is low, each rising edge of the pad clock shifts the
// register towards the last stage.
// Assumes: the pad clock is a slow level sampled in the system clock
// domain. There is deliberately no reset: the contents are undefined
// until the first capture.
module spad_pad_reg #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             pad_latch,
    input  logic             pad_clk,
    input  logic [NBITS-1:0] btn_n,
    input  logic             ser_in,
    output logic             pad_data
);
    logic             clk_prev_q;
    logic             shift_en;
    logic [NBITS-1:0] stage_q;

    // Remember the previous pad clock level, to find its rising edge
    always_ff @(posedge clk) begin
        clk_prev_q <= pad_clk;
    end

    assign shift_en = pad_clk & ~clk_prev_q & ~pad_latch;

    // One storage element per stage; stage 0 is fed from ser_in
    for (genvar g = 0; g < NBITS; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: button level, or the serial input on a shift
            always_ff @(posedge clk) begin
                if (pad_latch)
                    stage_q[g] <= btn_n[g];
                else if (shift_en)
                    stage_q[g] <= ser_in;
            end
        end else begin : g_rest
            // Later stage: button level, or its neighbour on a shift
            always_ff @(posedge clk) begin
                if (pad_latch)
                    stage_q[g] <= btn_n[g];
                else if (shift_en)
                    stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign pad_data = stage_q[NBITS-1];

endmodule

// File: rtl/spad_host.sv
// Module: spad_host
// Host poller. On each poll it raises the mode line, drops it, and
// samples the first bit before any clock pulse. It then issues NBITS
// pad clock pulses and samples after each of the first NBITS-1 of them.
// The pulse after the last sample moves the serial input into the
// final stage. Finally it waits a gap before the next poll.
// Assumes: NBITS >= 2, and a tick from spad_tick with DIV >= 2.
module spad_host #(
    parameter int NBITS       = 8,
    parameter int LATCH_TICKS = 2,
    parameter int GAP_TICKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pad_data,
    output logic             pad_latch,
    output logic             pad_clk,
    output logic [NBITS-1:0] buttons,
    output logic             buttons_valid
);
    import spad_pkg::*;

    localparam int IW = cnt_width(NBITS);
    localparam int TW = cnt_width((LATCH_TICKS > GAP_TICKS) ? LATCH_TICKS : GAP_TICKS);
    localparam logic [TW-1:0] LATCH_LAST = TW'(LATCH_TICKS - 1);
    localparam logic [TW-1:0] GAP_LAST   = TW'(GAP_TICKS - 1);
    localparam logic [IW-1:0] LAST_BIT   = IW'(NBITS - 1);
    localparam logic [IW-1:0] ALL_BITS   = IW'(NBITS);

    poll_phase_e      phase_q;
    logic [TW-1:0]    wait_q;
    logic [IW-1:0]    bit_q;
    logic [IW-1:0]    pulse_q;
    logic [NBITS-1:0] acc_q;
    logic [NBITS-1:0] acc_next;
    logic             take_sample;

    // Next accumulator value: shift in the inverted data line (1 = pressed)
    assign acc_next = {acc_q[NBITS-2:0], ~pad_data};

    // Sample at the end of the settle tick, and at the end of each high
    // phase while bits are still owed
    assign take_sample = tick &&
                         ((phase_q == PH_SETTLE) ||
                          ((phase_q == PH_HIGH) && (bit_q < ALL_BITS)));

    // Poll sequencer: phase, mode line and pad clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_LATCH;
            wait_q    <= '0;
            pulse_q   <= '0;
            pad_latch <= 1'b1;
            pad_clk   <= 1'b1;
        end else if (tick) begin
            case (phase_q)
                PH_LATCH: begin
                    if (wait_q == LATCH_LAST) begin
                        wait_q    <= '0;
                        pad_latch <= 1'b0;
                        phase_q   <= PH_SETTLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    pad_clk <= 1'b0;
                    phase_q <= PH_LOW;
                end
                PH_LOW: begin
                    pad_clk <= 1'b1;
                    pulse_q <= pulse_q + 1'b1;
                    phase_q <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (pulse_q == ALL_BITS) begin
                        phase_q <= PH_GAP;
                    end else begin
                        pad_clk <= 1'b0;
                        phase_q <= PH_LOW;
                    end
                end
                PH_GAP: begin
                    if (wait_q == GAP_LAST) begin
                        wait_q    <= '0;
                        pulse_q   <= '0;
                        pad_latch <= 1'b1;
                        phase_q   <= PH_LATCH;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: begin
                    phase_q   <= PH_LATCH;
                    pad_latch <= 1'b1;
                    pad_clk   <= 1'b1;
                end
            endcase
        end
    end

    // Sample collection, output vector and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q         <= '0;
            acc_q         <= '0;
            buttons       <= '0;
            buttons_valid <= 1'b0;
        end else begin
            buttons_valid <= 1'b0;
            if (tick && (phase_q == PH_LATCH))
                bit_q <= '0;
            if (take_sample) begin
                acc_q <= acc_next;
                bit_q <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    buttons       <= acc_next;
                    buttons_valid <= 1'b1;
                end
            end
        end
    end

    // R6: the pad clock stays high while the mode line is high
    assert_clk_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_latch |-> pad_clk);

    // R6: a rising pad clock edge only happens in serial mode
    assert_rise_in_serial_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_clk) |-> !pad_latch);

    // R6: no more than NBITS pulses in one poll
    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q <= ALL_BITS);

    // R7: the strobe never lasts more than one cycle
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buttons_valid |=> !buttons_valid);

endmodule

// File: rtl/spad_link.sv
// Module: spad_link
// Top level: the host poller and the pad register joined by the three
// link signals. Those signals are also brought out for observation.
// Assumes: btn_n and ser_in are already synchronous to clk.
module spad_link #(
    parameter int NBITS       = 8,
    parameter int DIV         = 4,
    parameter int LATCH_TICKS = 2,
    parameter int GAP_TICKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] btn_n,
    input  logic             ser_in,
    output logic             pad_latch,
    output logic             pad_clk,
    output logic             pad_data,
    output logic [NBITS-1:0] buttons,
    output logic             buttons_valid
);
    logic tick;

    spad_tick #(.DIV(DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    spad_host #(
        .NBITS       (NBITS),
        .LATCH_TICKS (LATCH_TICKS),
        .GAP_TICKS   (GAP_TICKS)
    ) host_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .pad_data      (pad_data),
        .pad_latch     (pad_latch),
        .pad_clk       (pad_clk),
        .buttons       (buttons),
        .buttons_valid (buttons_valid)
    );

    spad_pad_reg #(.NBITS(NBITS)) pad_i (
        .clk       (clk),
        .pad_latch (pad_latch),
        .pad_clk   (pad_clk),
        .btn_n     (btn_n),
        .ser_in    (ser_in),
        .pad_data  (pad_data)
    );

    // R1: one cycle of parallel mode puts button 8 on the data line
    assert_capture_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pad_latch) |-> (pad_data == $past(btn_n[NBITS-1])));

endmodule

// File: tb/spad_link_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for spad_link. The driver queues the expected vector
// of each poll; the monitor checks the vectors and the link timing.
module spad_link_tb_top;
    localparam int NBITS = 8;
    localparam int DIV   = 4;
    localparam int LT    = 2;
    localparam int GT    = 4;
    localparam int POLL  = (LT + GT + 17) * DIV;
    localparam int NPOLL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NBITS-1:0] btn_n = '1;
    logic ser_in = 1'b0;
    logic pad_latch, pad_clk, pad_data, buttons_valid;
    logic [NBITS-1:0] buttons;

    int n_checks = 0;
    int n_fail = 0;
    int polls_seen = 0;
    logic [NBITS-1:0] exp_q[$];

    always #2 clk = ~clk;

    spad_link #(.NBITS(NBITS), .DIV(DIV), .LATCH_TICKS(LT), .GAP_TICKS(GT)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .ser_in(ser_in),
        .pad_latch(pad_latch), .pad_clk(pad_clk), .pad_data(pad_data),
        .buttons(buttons), .buttons_valid(buttons_valid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: scoreboard pops, pulse count, clear value and phase widths
    logic prev_latch = 1'b1, prev_clk = 1'b1, prev_valid = 1'b0;
    logic last_data = 1'b0, ser_at_fall = 1'b0;
    bit   seen_fall = 1'b0, first_fall = 1'b1;
    int   pulses = 0, latch_run = 0, low_run = 0;
    longint cyc = 0, last_valid = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (buttons_valid) begin
                check("R7 strobe width", prev_valid, 0);
                if (exp_q.size() == 0) begin
                    check("R5 unexpected strobe", 1, 0);
                end else begin
                    // Vector reflects capture order and inversion (R2 R3 R5)
                    check("R2 R3 R5 vector", buttons, exp_q.pop_front());
                end
                if (last_valid >= 0) check("R9 strobe period", cyc - last_valid, POLL);
                last_valid = cyc;
                polls_seen++;
            end
            if (pad_clk && !prev_clk) begin
                check("R6 edge in serial mode", pad_latch, 0);
                check("R9 low phase", low_run, DIV);
                pulses++;
            end
            if (!pad_clk) low_run++; else low_run = 0;
            if (!pad_latch) last_data = pad_data;
            if (pad_latch && !prev_latch && seen_fall) begin
                check("R6 pulses per poll", pulses, NBITS);
                check("R4 clear value", last_data, ser_at_fall);
            end
            if (pad_latch && !prev_latch) pulses = 0;
            if (!pad_latch && prev_latch) begin
                if (!first_fall) check("R9 latch width", latch_run, LT * DIV);
                first_fall = 1'b0;
                seen_fall = 1'b1;
                ser_at_fall = ser_in;
            end
            if (pad_latch) latch_run++; else latch_run = 0;
            prev_latch = pad_latch;
            prev_clk = pad_clk;
            prev_valid = buttons_valid;
        end
    end

    // Driver: one pattern per poll, scrambled as soon as serial mode starts
    initial begin
        repeat (5) @(negedge clk);
        check("R8 reset latch", pad_latch, 1);
        check("R8 reset clk", pad_clk, 1);
        check("R8 reset buttons", buttons, 0);
        check("R8 reset strobe", buttons_valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NPOLL; i++) begin
            logic [NBITS-1:0] p;
            case (i)
                0: p = 8'hFF;
                1: p = 8'h00;
                2: p = 8'h7F;
                3: p = 8'hFE;
                default: p = 8'(i * 37 + 11);
            endcase
            do @(negedge clk); while (!pad_latch);
            btn_n = p;
            ser_in = i[0];
            exp_q.push_back(~p);
            repeat (2) @(negedge clk);
            if (pad_latch) check("R1 capture level", pad_data, p[NBITS-1]);
            do @(negedge clk); while (pad_latch);
            btn_n = ~p;  // must not affect this poll (R3)
        end
        while (polls_seen < NPOLL) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 0);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog R7", polls_seen, NPOLL);
        finish_run();
    end
endmodule